// File: doc/BRIEF.md
# Operand Address Generator

This block turns the addressing byte of a two-operand instruction, together with the displacement bytes that follow it, into the address of the memory operand. The addressing byte holds a 2-bit mode field in bits 7:6, a 3-bit register field in bits 5:3 (not used here) and a 3-bit register-or-memory field in bits 2:0. From these fields and the current pointer registers, the block forms a 16-bit offset. It also selects the segment for the access, either by its default rule or from an override prefix. It then forms the 20-bit physical address and reports how many displacement bytes the instruction uses. When the mode selects a register operand, the block reports that case and the register index instead.

All results are registered. Inputs presented before a rising clock edge appear on the outputs after that edge. The block is placed between instruction fetch and the memory access stage. The fetch logic uses the displacement-byte count to advance past the consumed bytes.

Top module: `ea_gen`

## Requirements
- R1: For mode 00, 01 or 10, the memory field selects the base sum: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP, 111 BX. The one exception is R2.
- R2: Mode 00 with memory field 110 uses no register. The offset is the direct 16-bit value {disp_hi, disp_lo}, the displacement count is 2, and the default segment is DS.
- R3: Mode 01 adds disp_lo, sign-extended to 16 bits, to the base sum and reports a count of 1. Mode 00 (other than R2) adds nothing and reports a count of 0.
- R4: Mode 10 adds {disp_hi, disp_lo} (low byte first in the stream) to the base sum and reports a count of 2.
- R5: Offset arithmetic wraps modulo 65536.
- R6: Mode 11 sets is_reg to 1 and reg_idx to the memory field. The count is 0, and ofs and phys are 0.
- R7: With no valid override, an address whose base is BP (fields 010, 011, and 110 in modes 01/10) uses SS (seg_code 2). All other memory addresses use DS (seg_code 3). The seg_code values are 0 for ES, 1 for CS, 2 for SS and 3 for DS.
- R8: When pfx_valid is 1 and pfx_byte matches 001ss110, segment ss replaces the default. A byte of any other form, or pfx_valid at 0, leaves the default unchanged.
- R9: phys equals (selected segment value × 16 + ofs) mod 2^20.
- R10: Results appear one clock after the inputs. During reset, the outputs are ofs 0, seg_code 3, is_reg 0, reg_idx 0, disp_cnt 0 and phys 0. The displacement count is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| modrm | input | 8 | Addressing byte: mode[7:6], register field[5:3], memory field[2:0] |
| disp_lo | input | 8 | First displacement byte |
| disp_hi | input | 8 | Second displacement byte |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| pfx_valid | input | 1 | A prefix byte is present |
| pfx_byte | input | 8 | Prefix byte |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| ofs | output | 16 | Operand offset |
| seg_code | output | 2 | Selected segment: 0 ES, 1 CS, 2 SS, 3 DS |
| is_reg | output | 1 | Operand is a register |
| reg_idx | output | 3 | Register index when is_reg is 1 |
| disp_cnt | output | 2 | Displacement bytes consumed |
| phys | output | 20 | Physical address |

## Verification
On every cycle, the assertions check the relation between inputs and the registered results one clock later. They cover the following:
- A register operand reports no displacement and no address.
- Mode 01 always reports one byte.
- The direct-address form copies its two bytes into the offset.
- A well-formed override prefix fixes the segment code.

Only the bench scenarios can show the actual base sums and the BP-to-SS defaulting. They also show the sign extension of negative byte displacements, the 16-bit and 20-bit wraparound, and that malformed or absent prefixes are ignored.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int OFS_W   = 16;
    localparam int PHYS_W  = 20;
    localparam int SEG_SHL = 4;
    localparam int CNT_W   = 2;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_code_e;

    typedef struct packed {
        logic [OFS_W-1:0]  ofs;
        seg_code_e         seg;
        logic              is_reg;
        logic [2:0]        reg_idx;
        logic [CNT_W-1:0]  cnt;
        logic [PHYS_W-1:0] phys;
    } ea_res_t;
endpackage

// File: rtl/ea_base_idx.sv
module ea_base_idx #(
    parameter int W = 16
) (
    input  logic [1:0]   mode,
    input  logic [2:0]   rm,
    input  logic [W-1:0] bx,
    input  logic [W-1:0] bp,
    input  logic [W-1:0] si,
    input  logic [W-1:0] di,
    output logic [W-1:0] base_sum,
    output logic         uses_bp
);
    logic direct;

    always_comb begin
        direct   = (mode == 2'b00) && (rm == 3'b110);
        base_sum = '0;
        uses_bp  = 1'b0;
        case (rm)
            3'b000: base_sum = bx + si;
            3'b001: base_sum = bx + di;
            3'b010: begin base_sum = bp + si; uses_bp = 1'b1; end
            3'b011: begin base_sum = bp + di; uses_bp = 1'b1; end
            3'b100: base_sum = si;
            3'b101: base_sum = di;
            3'b110: begin base_sum = bp; uses_bp = 1'b1; end
            default: base_sum = bx;
        endcase
        if (direct) begin
            base_sum = '0;
            uses_bp  = 1'b0;
        end
    end
endmodule

// File: rtl/ea_disp.sv
module ea_disp #(
    parameter int W     = 16,
    parameter int CNT_W = 2
) (
    input  logic [1:0]       mode,
    input  logic [2:0]       rm,
    input  logic [7:0]       lo,
    input  logic [7:0]       hi,
    output logic [W-1:0]     disp,
    output logic [CNT_W-1:0] cnt
);
    localparam int EXT = W - 8;

    always_comb begin
        disp = '0;
        cnt  = '0;
        case (mode)
            2'b00: if (rm == 3'b110) begin
                disp = W'({hi, lo});
                cnt  = CNT_W'(2);
            end
            2'b01: begin
                disp = {{EXT{lo[7]}}, lo};
                cnt  = CNT_W'(1);
            end
            2'b10: begin
                disp = W'({hi, lo});
                cnt  = CNT_W'(2);
            end
            default: begin
                disp = '0;
                cnt  = '0;
            end
        endcase
    end
endmodule

// File: rtl/ea_seg_pick.sv
module ea_seg_pick
    import ea_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic          pfx_valid,
    input  logic [7:0]    pfx_byte,
    input  logic          uses_bp,
    input  logic [SW-1:0] es,
    input  logic [SW-1:0] cs,
    input  logic [SW-1:0] ss,
    input  logic [SW-1:0] ds,
    output seg_code_e     code,
    output logic [SW-1:0] value
);
    logic ovr_hit;

    always_comb begin
        ovr_hit = pfx_valid && (pfx_byte[7:5] == 3'b001) && (pfx_byte[2:0] == 3'b110);
        if (ovr_hit)
            code = seg_code_e'(pfx_byte[4:3]);
        else if (uses_bp)
            code = SEG_SS;
        else
            code = SEG_DS;
        case (code)
            SEG_ES:  value = es;
            SEG_CS:  value = cs;
            SEG_SS:  value = ss;
            default: value = ds;
        endcase
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int RW = OFS_W,
    parameter int PW = PHYS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    modrm,
    input  logic [7:0]    disp_lo,
    input  logic [7:0]    disp_hi,
    input  logic [RW-1:0] reg_bx,
    input  logic [RW-1:0] reg_bp,
    input  logic [RW-1:0] reg_si,
    input  logic [RW-1:0] reg_di,
    input  logic          pfx_valid,
    input  logic [7:0]    pfx_byte,
    input  logic [RW-1:0] seg_es,
    input  logic [RW-1:0] seg_cs,
    input  logic [RW-1:0] seg_ss,
    input  logic [RW-1:0] seg_ds,
    output logic [RW-1:0] ofs,
    output logic [1:0]    seg_code,
    output logic          is_reg,
    output logic [2:0]    reg_idx,
    output logic [1:0]    disp_cnt,
    output logic [PW-1:0] phys
);
    localparam int PAD = PW - RW;

    logic [1:0]       mode;
    logic [2:0]       rm;
    logic [RW-1:0]    base_sum;
    logic             uses_bp;
    logic [RW-1:0]    disp;
    logic [CNT_W-1:0] cnt;
    seg_code_e        sel_code;
    logic [RW-1:0]    sel_val;
    ea_res_t          res_d, res_q;

    assign mode = modrm[7:6];
    assign rm   = modrm[2:0];

    ea_base_idx #(.W(RW)) u_base (
        .mode(mode), .rm(rm), .bx(reg_bx), .bp(reg_bp), .si(reg_si), .di(reg_di),
        .base_sum(base_sum), .uses_bp(uses_bp)
    );

    ea_disp #(.W(RW), .CNT_W(CNT_W)) u_disp (
        .mode(mode), .rm(rm), .lo(disp_lo), .hi(disp_hi), .disp(disp), .cnt(cnt)
    );

    ea_seg_pick #(.SW(RW)) u_seg (
        .pfx_valid(pfx_valid), .pfx_byte(pfx_byte), .uses_bp(uses_bp),
        .es(seg_es), .cs(seg_cs), .ss(seg_ss), .ds(seg_ds),
        .code(sel_code), .value(sel_val)
    );

    always_comb begin
        res_d = '0;
        if (mode == 2'b11) begin
            res_d.is_reg  = 1'b1;
            res_d.reg_idx = rm;
            res_d.seg     = SEG_DS;
        end else begin
            res_d.ofs  = base_sum + disp;
            res_d.seg  = sel_code;
            res_d.cnt  = cnt;
            res_d.phys = ({{PAD{1'b0}}, sel_val} << SEG_SHL) + {{PAD{1'b0}}, res_d.ofs};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= '0;
            res_q.seg <= SEG_DS;
        end else begin
            res_q <= res_d;
        end
    end

    assign ofs      = res_q.ofs;
    assign seg_code = res_q.seg;
    assign is_reg   = res_q.is_reg;
    assign reg_idx  = res_q.reg_idx;
    assign disp_cnt = res_q.cnt;
    assign phys     = res_q.phys;

    assert_reg_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_reg |-> (disp_cnt == 2'd0 && ofs == '0 && phys == '0));

    assert_cnt_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        disp_cnt != 2'd3);

    assert_byte_disp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (modrm[7:6] == 2'b01) |=> (disp_cnt == 2'd1 && !is_reg));

    assert_direct_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (modrm[7:6] == 2'b00 && modrm[2:0] == 3'b110)
        |=> (ofs == $past({disp_hi, disp_lo}) && disp_cnt == 2'd2));

    assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pfx_valid && pfx_byte[7:5] == 3'b001 && pfx_byte[2:0] == 3'b110 && modrm[7:6] != 2'b11)
        |=> (seg_code == $past(pfx_byte[4:3])));
endmodule

// File: tb/ea_gen_bench.sv
`timescale 1ns/1ps
module ea_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  modrm = '0, disp_lo = '0, disp_hi = '0, pfx_byte = '0;
    logic        pfx_valid = 1'b0;
    logic [15:0] reg_bx = 16'h1000, reg_bp = 16'h2000, reg_si = 16'h0030, reg_di = 16'h0004;
    logic [15:0] seg_es = 16'h1111, seg_cs = 16'h2222, seg_ss = 16'h3000, seg_ds = 16'h4000;
    logic [15:0] ofs;
    logic [1:0]  seg_code, disp_cnt;
    logic        is_reg;
    logic [2:0]  reg_idx;
    logic [19:0] phys;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ea_gen u_ea_gen (
        .clk(clk), .rst_n(rst_n), .modrm(modrm), .disp_lo(disp_lo), .disp_hi(disp_hi),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .pfx_valid(pfx_valid), .pfx_byte(pfx_byte),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .ofs(ofs), .seg_code(seg_code), .is_reg(is_reg), .reg_idx(reg_idx),
        .disp_cnt(disp_cnt), .phys(phys)
    );

    function automatic logic [19:0] seg_val(input logic [1:0] c);
        case (c)
            2'd0: return {4'h0, seg_es};
            2'd1: return {4'h0, seg_cs};
            2'd2: return {4'h0, seg_ss};
            default: return {4'h0, seg_ds};
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] m, input logic [7:0] lo, input logic [7:0] hi,
                         input logic pv, input logic [7:0] pb);
        @(negedge clk);
        modrm = m; disp_lo = lo; disp_hi = hi; pfx_valid = pv; pfx_byte = pb;
        @(negedge clk);
    endtask

    task automatic expect_mem(input string req, input logic [15:0] eo, input logic [1:0] es,
                              input logic [1:0] ec);
        logic [19:0] ep;
        ep = (seg_val(es) << 4) + {4'h0, eo};
        chk(req, "ofs", 32'(ofs), 32'(eo));
        chk(req, "seg", 32'(seg_code), 32'(es));
        chk(req, "cnt", 32'(disp_cnt), 32'(ec));
        chk(req, "is_reg", 32'(is_reg), 32'd0);
        chk(req, "phys", 32'(phys), 32'(ep));
    endtask

    task automatic t_reset();
        chk("R10", "reset ofs", 32'(ofs), 0);
        chk("R10", "reset seg", 32'(seg_code), 3);
        chk("R10", "reset is_reg", 32'(is_reg), 0);
        chk("R10", "reset cnt", 32'(disp_cnt), 0);
        chk("R10", "reset phys", 32'(phys), 0);
    endtask

    task automatic t_table_r1();
        logic [15:0] sums [8];
        sums = '{16'h1030, 16'h1004, 16'h2030, 16'h2004, 16'h0030, 16'h0004, 16'h0000, 16'h1000};
        for (int r = 0; r < 8; r++) begin
            if (r != 6) begin
                apply({2'b00, 3'b000, 3'(r)}, 8'h55, 8'h66, 1'b0, 8'h00);
                expect_mem("R1/R7", sums[r], (r == 2 || r == 3) ? 2'd2 : 2'd3, 2'd0);
            end
        end
    endtask

    task automatic t_direct_r2();
        apply(8'b00_000_110, 8'h34, 8'h12, 1'b0, 8'h00);
        expect_mem("R2", 16'h1234, 2'd3, 2'd2);
    endtask

    task automatic t_byte_disp_r3();
        apply(8'b01_000_110, 8'hF0, 8'hAA, 1'b0, 8'h00);
        expect_mem("R3", 16'h1FF0, 2'd2, 2'd1);
        apply(8'b01_000_111, 8'h7F, 8'hAA, 1'b0, 8'h00);
        expect_mem("R3", 16'h107F, 2'd3, 2'd1);
    endtask

    task automatic t_word_disp_r4();
        apply(8'b10_000_100, 8'h00, 8'h80, 1'b0, 8'h00);
        expect_mem("R4", 16'h8030, 2'd3, 2'd2);
        apply(8'b10_000_110, 8'h01, 8'h02, 1'b0, 8'h00);
        expect_mem("R4/R7", 16'h2201, 2'd2, 2'd2);
    endtask

    task automatic t_wrap_r5();
        apply(8'b10_000_000, 8'h00, 8'hF0, 1'b0, 8'h00);
        expect_mem("R5", 16'h0030, 2'd3, 2'd2);
        apply(8'b01_000_101, 8'hF0, 8'h00, 1'b0, 8'h00);
        expect_mem("R5", 16'hFFF4, 2'd3, 2'd1);
    endtask

    task automatic t_register_r6();
        apply(8'b11_010_101, 8'h12, 8'h34, 1'b1, 8'h26);
        chk("R6", "is_reg", 32'(is_reg), 1);
        chk("R6", "reg_idx", 32'(reg_idx), 5);
        chk("R6", "cnt", 32'(disp_cnt), 0);
        chk("R6", "ofs", 32'(ofs), 0);
        chk("R6", "phys", 32'(phys), 0);
    endtask

    task automatic t_override_r8();
        apply(8'b01_000_010, 8'h10, 8'h00, 1'b1, 8'h26);
        expect_mem("R8 ES", 16'h2040, 2'd0, 2'd1);
        apply(8'b00_000_111, 8'h00, 8'h00, 1'b1, 8'h2E);
        expect_mem("R8 CS", 16'h1000, 2'd1, 2'd0);
        apply(8'b00_000_000, 8'h00, 8'h00, 1'b1, 8'h36);
        expect_mem("R8 SS", 16'h1030, 2'd2, 2'd0);
        apply(8'b00_000_010, 8'h00, 8'h00, 1'b1, 8'h3E);
        expect_mem("R8 DS", 16'h2030, 2'd3, 2'd0);
        apply(8'b00_000_010, 8'h00, 8'h00, 1'b1, 8'h27);
        expect_mem("R8 malformed", 16'h2030, 2'd2, 2'd0);
        apply(8'b00_000_111, 8'h00, 8'h00, 1'b0, 8'h26);
        expect_mem("R8 absent", 16'h1000, 2'd3, 2'd0);
    endtask

    task automatic t_phys_wrap_r9();
        seg_ds = 16'hFFFF;
        apply(8'b00_000_110, 8'h20, 8'h00, 1'b0, 8'h00);
        chk("R9", "phys wrap", 32'(phys), 32'h00010);
        chk("R9", "ofs", 32'(ofs), 32'h0020);
        seg_ds = 16'h4000;
    endtask

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_table_r1();
        t_direct_r2();
        t_byte_disp_r3();
        t_word_disp_r4();
        t_wrap_r5();
        t_register_r6();
        t_override_r8();
        t_phys_wrap_r9();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule